// File: doc/BRIEF.md
# Immediate-Compare Compact Branch Resolver

This block decides the outcome of a compact (no delay slot) branch that compares one register operand against a small unsigned immediate, or that tests one bit of that register. It receives the fetched 32-bit instruction word, the address of that instruction, the operand value already read from the register file, a flag saying the operand index names the hard-wired zero register, and a flag saying the core runs in 64-bit mode. One clock later it reports whether the branch redirects fetch, falls through, or must be trapped as a reserved instruction. It also reports the branch destination and the address fetch should continue from.

When the operand names the zero register, the operand is forced to zero whatever value the register port carries. Some encodings therefore become unconditional branches and others become no-ops. A no-op produces a fall-through result and never an exception. Bit-test forms use the immediate as a bit index. An index that reaches into the upper half of a 64-bit register is illegal while the core is in 32-bit mode.

Top module: `imm_branch_resolver`

## Requirements
- R1: Instruction fields: bits 20..18 hold the operation code, bits 17..11 the unsigned immediate, bits 10..1 offset bits 10..1, and bit 0 the sign, which becomes offset bit 11 and is extended upward. Offset bit 0 is zero. `br_target` = pc + 4 + offset. Bits 31..21 are ignored.
- R2: Every `in_valid` cycle yields `out_valid` exactly one clock later, with exactly one of `taken`, `not_taken`, `ri_exc` set. Without `out_valid` all three are low.
- R3: `next_pc` equals `br_target` when `taken` is set and pc + 4 otherwise. Nothing is a delay slot.
- R4: Code 0 branches when the operand equals the immediate, and code 4 branches when it differs. With `rt_zero` set, the operand is zero regardless of `rt_val`. So code 0 with immediate 0 always branches and with a nonzero immediate is a no-op, and code 4 is the reverse.
- R5: Code 2 branches if operand >= immediate, and code 6 branches if operand < immediate. Both are signed compares of the operand against the zero-extended immediate.
- R6: Code 3 (>=) and code 7 (<) compare the operand and the immediate as unsigned numbers. With `rt_zero` set and immediate 0, code 3 always branches.
- R7: Code 1 branches when operand bit number imm is 0, and code 5 branches when it is 1. Bit positions at or beyond the data width read as 0. With `rt_zero` set, code 1 always branches and code 5 never does.
- R8: Codes 1 and 5 with imm >= 32 while `mode64` is low raise `ri_exc`, even when `rt_zero` is set. With `mode64` high no exception is raised.
- R9: After reset, `out_valid`, `taken`, `not_taken` and `ri_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Branch instruction word |
| pc | input | PC_W | Address of the instruction |
| rt_val | input | XLEN | Operand value from the register file |
| rt_zero | input | 1 | Operand index is the zero register |
| mode64 | input | 1 | Core is in 64-bit mode |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Branch redirects fetch |
| not_taken | output | 1 | Fetch continues at pc + 4 (also for no-ops) |
| ri_exc | output | 1 | Reserved-instruction exception |
| br_target | output | PC_W | pc + 4 + offset |
| next_pc | output | PC_W | Address to fetch next |

## Verification
Every result is due exactly one clock after the cycle in which `in_valid` was sampled, and there is no other latency. The driver stamps each expected item with its issue cycle. The monitor samples at the falling edge and requires the head item to appear when the cycle count has moved on by one. It flags a result that comes early, comes late, or appears without an item. In idle cycles between bursts the bench also checks that all outcome flags stay low.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [2:0] {
        OP_EQ   = 3'd0,
        OP_BCLR = 3'd1,
        OP_GE   = 3'd2,
        OP_GEU  = 3'd3,
        OP_NE   = 3'd4,
        OP_BSET = 3'd5,
        OP_LT   = 3'd6,
        OP_LTU  = 3'd7
    } br_op_e;

    localparam int INSTR_W   = 32;
    localparam int OP_LSB    = 18;
    localparam int IMM_LSB   = 11;
    localparam int OFF_BITS  = 12;
    localparam int NARROW_W  = 32;

endpackage

// File: rtl/ibr_fields.sv
module ibr_fields
    import ibr_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IMM_W = 7
) (
    input  logic [INSTR_W-1:0] instr,
    output br_op_e             op,
    output logic [IMM_W-1:0]   imm,
    output logic [PC_W-1:0]    offset
);
    localparam int EXT_W = PC_W - OFF_BITS;

    logic [OFF_BITS-1:0] off_raw;

    always_comb begin
        op      = br_op_e'(instr[OP_LSB +: 3]);
        imm     = instr[IMM_LSB +: IMM_W];
        off_raw = {instr[0], instr[OFF_BITS-2:1], 1'b0};
        offset  = {{EXT_W{off_raw[OFF_BITS-1]}}, off_raw};
    end
endmodule

// File: rtl/ibr_addr.sv
module ibr_addr #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] offset,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] tgt_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    always_comb begin
        seq_pc = pc + STEP;
        tgt_pc = seq_pc + offset;
    end
endmodule

// File: rtl/ibr_cond.sv
module ibr_cond
    import ibr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 7
) (
    input  br_op_e           op,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  operand,
    input  logic             mode64,
    output logic             hit,
    output logic             ri
);
    localparam int IDX_W = $clog2(XLEN);
    localparam int IMM_ZX = XLEN - IMM_W;

    logic [XLEN-1:0] imm_zx;
    logic            sel_bit;
    logic            idx_inside;
    logic            wide_idx;
    logic            eq_c, slt_c, ult_c;

    generate
        if (XLEN > (1 << IMM_W)) begin : g_all_inside
            assign idx_inside = 1'b1;
        end else begin : g_range
            assign idx_inside = ({1'b0, imm} < (IMM_W+1)'(XLEN));
        end
    endgenerate

    always_comb begin
        imm_zx   = {{IMM_ZX{1'b0}}, imm};
        eq_c     = (operand == imm_zx);
        slt_c    = ($signed(operand) < $signed(imm_zx));
        ult_c    = (operand < imm_zx);
        sel_bit  = idx_inside ? operand[imm[IDX_W-1:0]] : 1'b0;
        wide_idx = ({1'b0, imm} >= (IMM_W+1)'(NARROW_W));
        ri       = 1'b0;
        hit      = 1'b0;
        unique case (op)
            OP_EQ:   hit = eq_c;
            OP_NE:   hit = !eq_c;
            OP_GE:   hit = !slt_c;
            OP_LT:   hit = slt_c;
            OP_GEU:  hit = !ult_c;
            OP_LTU:  hit = ult_c;
            OP_BCLR: begin
                hit = !sel_bit;
                ri  = wide_idx && !mode64;
            end
            OP_BSET: begin
                hit = sel_bit;
                ri  = wide_idx && !mode64;
            end
            default: ri = 1'b1;
        endcase
    end
endmodule

// File: rtl/imm_branch_resolver.sv
module imm_branch_resolver
    import ibr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PC_W  = 32,
    parameter int IMM_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [PC_W-1:0]     pc,
    input  logic [XLEN-1:0]     rt_val,
    input  logic                rt_zero,
    input  logic                mode64,
    output logic                out_valid,
    output logic                taken,
    output logic                not_taken,
    output logic                ri_exc,
    output logic [PC_W-1:0]     br_target,
    output logic [PC_W-1:0]     next_pc
);
    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic            fall;
        logic            ri;
        logic [PC_W-1:0] tgt;
        logic [PC_W-1:0] nxt;
    } res_t;

    br_op_e           op_w;
    logic [IMM_W-1:0] imm_w;
    logic [PC_W-1:0]  off_w;
    logic [PC_W-1:0]  seq_w;
    logic [PC_W-1:0]  tgt_w;
    logic [XLEN-1:0]  opnd_w;
    logic             hit_w;
    logic             ri_w;

    res_t res_d, res_q;

    ibr_fields #(.PC_W(PC_W), .IMM_W(IMM_W)) u_fields (
        .instr  (instr),
        .op     (op_w),
        .imm    (imm_w),
        .offset (off_w)
    );

    ibr_addr #(.PC_W(PC_W)) u_addr (
        .pc     (pc),
        .offset (off_w),
        .seq_pc (seq_w),
        .tgt_pc (tgt_w)
    );

    assign opnd_w = rt_zero ? '0 : rt_val;

    ibr_cond #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cond (
        .op      (op_w),
        .imm     (imm_w),
        .operand (opnd_w),
        .mode64  (mode64),
        .hit     (hit_w),
        .ri      (ri_w)
    );

    always_comb begin
        res_d      = res_q;
        res_d.vld  = in_valid;
        res_d.tkn  = in_valid && !ri_w && hit_w;
        res_d.fall = in_valid && !ri_w && !hit_w;
        res_d.ri   = in_valid && ri_w;
        if (in_valid) begin
            res_d.tgt = tgt_w;
            res_d.nxt = (hit_w && !ri_w) ? tgt_w : seq_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tkn;
    assign not_taken = res_q.fall;
    assign ri_exc    = res_q.ri;
    assign br_target = res_q.tgt;
    assign next_pc   = res_q.nxt;

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({taken, not_taken, ri_exc}));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !not_taken && !ri_exc));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (next_pc == br_target));

    a_r3_fall_seq: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(pc) + PC_W'(4)));

    a_r8_ri_source: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!ri_exc || (($past(instr[OP_LSB +: 2]) == 2'b01)
                      && !$past(mode64) && ($past(instr[17:16]) != 2'b00))));
endmodule

// File: tb/imm_branch_resolver_tb_top.sv
module imm_branch_resolver_tb_top;
    localparam int XLEN = 32;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [PC_W-1:0] pc = '0;
    logic [XLEN-1:0] rt_val = '0;
    logic            rt_zero = 1'b0;
    logic            mode64 = 1'b0;
    logic            out_valid, taken, not_taken, ri_exc;
    logic [PC_W-1:0] br_target, next_pc;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          at;
        bit          tk;
        bit          nt;
        bit          ri;
        logic [31:0] tgt;
        logic [31:0] nxt;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    imm_branch_resolver #(.XLEN(XLEN), .PC_W(PC_W), .IMM_W(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .pc(pc), .rt_val(rt_val), .rt_zero(rt_zero), .mode64(mode64),
        .out_valid(out_valid), .taken(taken), .not_taken(not_taken),
        .ri_exc(ri_exc), .br_target(br_target), .next_pc(next_pc)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic void model(input logic [2:0] op, input logic [6:0] imm,
                                  input logic [31:0] rv, input bit rz, input bit m64,
                                  output bit tk, output bit ri);
        logic [31:0] v;
        logic [31:0] iz;
        bit b;
        v  = rz ? 32'd0 : rv;
        iz = {25'd0, imm};
        b  = (imm < 32) ? v[imm[4:0]] : 1'b0;
        ri = 0;
        tk = 0;
        case (op)
            3'd0: tk = (v == iz);
            3'd4: tk = (v != iz);
            3'd2: tk = ($signed(v) >= $signed(iz));
            3'd6: tk = ($signed(v) < $signed(iz));
            3'd3: tk = (v >= iz);
            3'd7: tk = (v < iz);
            3'd1: begin tk = !b; ri = (imm >= 32) && !m64; end
            default: begin tk = b; ri = (imm >= 32) && !m64; end
        endcase
        if (ri) tk = 0;
    endfunction

    // Driver: drive on falling edge, push expected item
    task automatic issue(input string tag, input logic [2:0] op, input logic [6:0] imm,
                         input logic [11:0] off, input logic [31:0] rv,
                         input bit rz, input bit m64, input logic [31:0] p);
        exp_t e;
        bit tk, ri;
        logic [31:0] o32;
        @(negedge clk);
        instr    = {11'h5A5, op, imm, off[10:1], off[11]};
        pc       = p;
        rt_val   = rv;
        rt_zero  = rz;
        mode64   = m64;
        in_valid = 1'b1;
        model(op, imm, rv, rz, m64, tk, ri);
        o32   = {{20{off[11]}}, off[11:1], 1'b0};
        e.at  = cyc;
        e.tk  = tk;
        e.ri  = ri;
        e.nt  = !tk && !ri;
        e.tgt = p + 32'd4 + o32;
        e.nxt = tk ? e.tgt : p + 32'd4;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr    = 32'hFFFF_FFFF;
        end
    endtask

    // Monitor: compare at falling edge, one cycle after issue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sb.size() > 0 && sb[0].at == cyc - 1) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, "out_valid R2", 32'(out_valid), 32'd1);
                    chk(e.tag, "taken", 32'(taken), 32'(e.tk));
                    chk(e.tag, "not_taken", 32'(not_taken), 32'(e.nt));
                    chk(e.tag, "ri_exc R8", 32'(ri_exc), 32'(e.ri));
                    chk(e.tag, "br_target R1", br_target, e.tgt);
                    chk(e.tag, "next_pc R3", next_pc, e.nxt);
                end else begin
                    chk("R2", "idle out_valid", 32'(out_valid), 32'd0);
                    chk("R2", "idle flags", {29'd0, taken, not_taken, ri_exc}, 32'd0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R9", "reset flags", {29'd0, taken, not_taken, ri_exc}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R1 offset extremes and field placement
        issue("R1 max fwd", 3'd0, 7'd9, 12'h7FE, 32'd9, 0, 0, 32'h0000_1000);
        issue("R1 max back", 3'd0, 7'd9, 12'h800, 32'd9, 0, 0, 32'h0000_1000);
        issue("R1 small back", 3'd4, 7'd1, 12'hFFE, 32'd2, 0, 0, 32'h8000_0000);
        // R4
        issue("R4 eq hit", 3'd0, 7'd100, 12'h010, 32'd100, 0, 0, 32'h200);
        issue("R4 eq miss", 3'd0, 7'd100, 12'h010, 32'd5, 0, 0, 32'h200);
        issue("R4 zero eq imm0", 3'd0, 7'd0, 12'h020, 32'hDEAD_BEEF, 1, 0, 32'h300);
        issue("R4 zero eq nop", 3'd0, 7'd3, 12'h020, 32'd3, 1, 0, 32'h300);
        issue("R4 ne hit", 3'd4, 7'd7, 12'h040, 32'd8, 0, 0, 32'h400);
        issue("R4 zero ne nop", 3'd4, 7'd0, 12'h040, 32'd1, 1, 0, 32'h400);
        issue("R4 zero ne uncond", 3'd4, 7'd5, 12'h040, 32'd5, 1, 0, 32'h400);
        idle(3);
        // R5
        issue("R5 ge neg", 3'd2, 7'd5, 12'h100, 32'hFFFF_FFFF, 0, 0, 32'h500);
        issue("R5 ge equal", 3'd2, 7'd5, 12'h100, 32'd5, 0, 0, 32'h500);
        issue("R5 lt neg", 3'd6, 7'd0, 12'h100, 32'h8000_0000, 0, 0, 32'h500);
        issue("R5 lt miss", 3'd6, 7'd127, 12'h100, 32'd127, 0, 0, 32'h500);
        issue("R5 zero ge imm0", 3'd2, 7'd0, 12'h100, 32'h8000_0000, 1, 0, 32'h500);
        // R6
        issue("R6 geu big", 3'd3, 7'd5, 12'h0FE, 32'hFFFF_FFFF, 0, 0, 32'h600);
        issue("R6 ltu hit", 3'd7, 7'd4, 12'h0FE, 32'd3, 0, 0, 32'h600);
        issue("R6 ltu big", 3'd7, 7'd4, 12'h0FE, 32'hFFFF_FFFF, 0, 0, 32'h600);
        issue("R6 zero geu imm0", 3'd3, 7'd0, 12'h0FE, 32'd1, 1, 0, 32'h600);
        issue("R6 zero ltu imm0", 3'd7, 7'd0, 12'h0FE, 32'd1, 1, 0, 32'h600);
        idle(1);
        // R7
        issue("R7 clr set bit", 3'd1, 7'd4, 12'h222, 32'h10, 0, 0, 32'h700);
        issue("R7 clr clear bit", 3'd1, 7'd3, 12'h222, 32'h10, 0, 0, 32'h700);
        issue("R7 set bit31", 3'd5, 7'd31, 12'h222, 32'h8000_0000, 0, 0, 32'h700);
        issue("R7 set bit0 miss", 3'd5, 7'd0, 12'h222, 32'hFFFF_FFFE, 0, 0, 32'h700);
        issue("R7 zero clr", 3'd1, 7'd2, 12'h222, 32'hFFFF_FFFF, 1, 0, 32'h700);
        issue("R7 zero set", 3'd5, 7'd2, 12'h222, 32'hFFFF_FFFF, 1, 0, 32'h700);
        issue("R7 wide clr m64", 3'd1, 7'd40, 12'h222, 32'hFFFF_FFFF, 0, 1, 32'h700);
        issue("R7 wide set m64", 3'd5, 7'd127, 12'h222, 32'hFFFF_FFFF, 0, 1, 32'h700);
        // R8
        issue("R8 clr idx32", 3'd1, 7'd32, 12'h222, 32'd0, 0, 0, 32'h800);
        issue("R8 set idx40", 3'd5, 7'd40, 12'h222, 32'hFFFF_FFFF, 0, 0, 32'h800);
        issue("R8 zero idx32", 3'd1, 7'd32, 12'h222, 32'd0, 1, 0, 32'h800);
        issue("R8 idx31 legal", 3'd1, 7'd31, 12'h222, 32'd0, 0, 0, 32'h800);
        idle(4);

        if (sb.size() != 0) chk("R2", "leftover results", 32'(sb.size()), 32'd0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule